// File: doc/BRIEF.md
# DRAM Start-up and Refresh Strobe Sequencer

This block drives the row strobe, column strobe and write enable of an asynchronous EDO DRAM. It covers start-up and refresh only. After reset it holds all strobes idle through a power-up pause. It then issues a counted burst of refresh cycles in which the column strobe falls before the row strobe, and only after that burst does it raise `ready_o`.

While ready, an internal interval timer requests one such refresh cycle per period. A request is latched until it is served. A level request on `self_ref_req_i` makes the block enter self-refresh. In self-refresh both strobes stay low for at least a minimum time and for as long as the request stays high. `busy_o` lets an external arbiter hold off other accesses while a sequence is in flight.

Every analog limit is a nanosecond parameter. Each one is converted to whole clock cycles by rounding up against `CLK_PERIOD_NS`. At the default 8 ns period the cycle counts are:

| Limit | Cycles |
|---|---|
| Power-up pause | 25000 |
| Column strobe setup before the row fall | 1 |
| Column strobe hold after the row fall | 2 |
| Column strobe high before its fall | 1 |
| Refresh row pulse | 7 |
| Row precharge | 4 |
| Refresh period | 1950 |
| Minimum self-refresh row low | 12500 |
| Self-refresh exit precharge | 14 |

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset, `ras_no`, `cas_no` and `we_no` are 1, `ready_o` is 0 and `busy_o` is 1. After reset is released, neither strobe goes low during the first 25000 cycles. This also holds when reset is asserted mid-sequence: the strobes return to 1 at once.
- R2: Exactly 8 refresh cycles, with the row strobe falling while the column strobe is low, occur before `ready_o` rises. Once high, `ready_o` stays high until reset.
- R3: In every cycle the column strobe has been low for at least 1 clock cycle when the row strobe falls. The row strobe never falls while the column strobe is high.
- R4: In a refresh cycle the column strobe stays low for at least 2 cycles after the row strobe falls.
- R5: The column strobe has been high for at least 1 cycle before it falls.
- R6: `we_no` is 1 at all times.
- R7: While ready and with no self-refresh request, successive refresh row-strobe falls are exactly 1950 cycles apart.
- R8: Between row-strobe pulses the row strobe stays high for at least 4 cycles.
- R9: `busy_o` is 1 whenever either strobe is low and while `ready_o` is 0. In the cycle `ready_o` rises, `busy_o` is 0.
- R10: In self-refresh the row strobe is low for max(12500, H) cycles, and the column strobe is low throughout. H is the number of cycles the request stays high after the column strobe is seen low.
- R11: A refresh that falls due during self-refresh is served first after exit. Its row strobe falls exactly 17 cycles after the self-refresh row strobe rises, that is 14 cycles of precharge plus 3.
- R12: A refresh row pulse lasts exactly 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| self_ref_req_i | input | 1 | Level request to enter and stay in self-refresh |
| ras_no | output | 1 | Row address strobe, active low, registered |
| cas_no | output | 1 | Column address strobe, active low, registered |
| we_no | output | 1 | Write enable, active low, held high |
| ready_o | output | 1 | Initialisation burst complete |
| busy_o | output | 1 | A sequence or initialisation is in progress |

## Verification
The outputs move on fixed cycle offsets, and the checks are written against those offsets:

- **Ordinary refresh:** when the engine is idle and a request is seen at edge t, the column strobe falls at edge t+2 and the row strobe at edge t+3.
- **Self-refresh exit:** the row strobe rises on the edge that follows the request being seen low, once the minimum count has run out.
- **Pending refresh after self-refresh:** the row strobe falls again 17 edges after it rose.

A monitor samples on the falling clock edge. It measures each high and low run of the strobes in whole cycles and compares the run lengths against these counts. Directed sequences also read the monitor's results one time step after that edge, so that no result depends on process order.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {CT_PAUSE, CT_INIT, CT_RUN} ctl_st_e;
  typedef enum logic [2:0] {EN_IDLE, EN_PRE, EN_CAS, EN_RAS, EN_RP} eng_st_e;

  // round up to whole cycles, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/drs_refresh_timer.sv
module drs_refresh_timer #(
  parameter int unsigned C_INT = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);
  localparam int unsigned TW = $clog2(C_INT + 1);
  localparam logic [TW-1:0] LAST = TW'(C_INT - 1);

  logic [TW-1:0] cnt_q;
  logic          pend_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == LAST);
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (!en_i || tick) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
      if (tick)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/drs_strobe_engine.sv
module drs_strobe_engine
  import dram_seq_pkg::*;
#(
  parameter int unsigned C_PRE  = 1,
  parameter int unsigned C_CSR  = 1,
  parameter int unsigned C_CHR  = 2,
  parameter int unsigned C_RASW = 7,
  parameter int unsigned C_RP   = 4,
  parameter int unsigned C_RASS = 12500,
  parameter int unsigned C_RPS  = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sr_i,
  input  logic sr_hold_i,
  output logic idle_o,
  output logic ras_no,
  output logic cas_no
);
  localparam int unsigned CW = $clog2(C_RASS + C_RASW + C_RPS + C_RP + 2);
  localparam logic [CW-1:0] L_PRE  = CW'(C_PRE - 1);
  localparam logic [CW-1:0] L_CSR  = CW'(C_CSR - 1);
  localparam logic [CW-1:0] L_CHR  = CW'(C_CHR - 1);
  localparam logic [CW-1:0] L_RASW = CW'(C_RASW - 1);
  localparam logic [CW-1:0] L_RP   = CW'(C_RP - 1);
  localparam logic [CW-1:0] L_RASS = CW'(C_RASS - 1);
  localparam logic [CW-1:0] L_RPS  = CW'(C_RPS - 1);
  localparam logic [CW-1:0] C_MAX  = {CW{1'b1}};

  eng_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          sr_q, ras_q, cas_q;
  logic          ras_done;
  logic [CW-1:0] rp_last;

  assign ras_done = sr_q ? ((cnt_q >= L_RASS) && !sr_hold_i) : (cnt_q == L_RASW);
  assign rp_last  = sr_q ? L_RPS : L_RP;
  assign idle_o   = (st_q == EN_IDLE);
  assign ras_no   = ras_q;
  assign cas_no   = cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= EN_IDLE;
      cnt_q <= '0;
      sr_q  <= 1'b0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      case (st_q)
        EN_IDLE: if (start_i) begin
          st_q  <= EN_PRE;
          cnt_q <= '0;
          sr_q  <= sr_i;
        end
        EN_PRE: begin
          if (cnt_q == L_PRE) begin
            st_q  <= EN_CAS;
            cnt_q <= '0;
            cas_q <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        EN_CAS: begin
          if (cnt_q == L_CSR) begin
            st_q  <= EN_RAS;
            cnt_q <= '0;
            ras_q <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        EN_RAS: begin
          if (ras_done) begin
            st_q  <= EN_RP;
            cnt_q <= '0;
            ras_q <= 1'b1;
            cas_q <= 1'b1;
          end else begin
            if (cnt_q != C_MAX) cnt_q <= cnt_q + 1'b1;
            if (!sr_q && cnt_q == L_CHR) cas_q <= 1'b1;
          end
        end
        EN_RP: begin
          if (cnt_q == rp_last) begin
            st_q  <= EN_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drs_init_ctrl.sv
module drs_init_ctrl
  import dram_seq_pkg::*;
#(
  parameter int unsigned C_PAUSE = 25000,
  parameter int unsigned N_INIT  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eng_idle_i,
  input  logic pend_i,
  input  logic sr_req_i,
  output logic start_o,
  output logic sr_o,
  output logic ready_o,
  output logic busy_o
);
  localparam int unsigned PW = $clog2(C_PAUSE + 1);
  localparam int unsigned IW = $clog2(N_INIT + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(C_PAUSE - 1);
  localparam logic [IW-1:0] INIT_CNT   = IW'(N_INIT);

  ctl_st_e       st_q;
  logic [PW-1:0] pcnt_q;
  logic [IW-1:0] nis_q;

  always_comb begin
    start_o = 1'b0;
    sr_o    = 1'b0;
    case (st_q)
      CT_INIT: start_o = eng_idle_i && (nis_q != INIT_CNT);
      CT_RUN: if (eng_idle_i) begin
        if (pend_i) start_o = 1'b1;
        else if (sr_req_i) begin
          start_o = 1'b1;
          sr_o    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign ready_o = (st_q == CT_RUN);
  assign busy_o  = !ready_o || !eng_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CT_PAUSE;
      pcnt_q <= '0;
      nis_q  <= '0;
    end else begin
      case (st_q)
        CT_PAUSE: begin
          if (pcnt_q == PAUSE_LAST) st_q <= CT_INIT;
          else                      pcnt_q <= pcnt_q + 1'b1;
        end
        CT_INIT: begin
          if (start_o) nis_q <= nis_q + 1'b1;
          else if (eng_idle_i && nis_q == INIT_CNT) st_q <= CT_RUN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_PAUSE_NS    = 200000,
  parameter int unsigned N_INIT        = 8,
  parameter int unsigned T_CSR_NS      = 5,
  parameter int unsigned T_CHR_NS      = 10,
  parameter int unsigned T_RPC_NS      = 5,
  parameter int unsigned T_RAS_NS      = 50,
  parameter int unsigned T_RP_NS       = 30,
  parameter int unsigned T_REF_NS      = 15600,
  parameter int unsigned T_RASS_NS     = 100000,
  parameter int unsigned T_RPS_NS      = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic self_ref_req_i,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic ready_o,
  output logic busy_o
);
  localparam int unsigned C_PAUSE = ns_to_cyc(T_PAUSE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_CSR   = ns_to_cyc(T_CSR_NS, CLK_PERIOD_NS);
  localparam int unsigned C_CHR   = ns_to_cyc(T_CHR_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RPC   = ns_to_cyc(T_RPC_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RAS   = ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RP    = ns_to_cyc(T_RP_NS, CLK_PERIOD_NS);
  localparam int unsigned C_INT   = ns_to_cyc(T_REF_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RASS  = ns_to_cyc(T_RASS_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RPS   = ns_to_cyc(T_RPS_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RASW  = (C_RAS > C_CHR) ? C_RAS : C_CHR;

  logic eng_idle, pend, start, sr_sel;

  drs_init_ctrl #(
    .C_PAUSE(C_PAUSE),
    .N_INIT (N_INIT)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eng_idle_i(eng_idle),
    .pend_i    (pend),
    .sr_req_i  (self_ref_req_i),
    .start_o   (start),
    .sr_o      (sr_sel),
    .ready_o   (ready_o),
    .busy_o    (busy_o)
  );

  drs_refresh_timer #(.C_INT(C_INT)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ready_o),
    .clr_i (start && !sr_sel),
    .pend_o(pend)
  );

  drs_strobe_engine #(
    .C_PRE (C_RPC),
    .C_CSR (C_CSR),
    .C_CHR (C_CHR),
    .C_RASW(C_RASW),
    .C_RP  (C_RP),
    .C_RASS(C_RASS),
    .C_RPS (C_RPS)
  ) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .sr_i     (sr_sel),
    .sr_hold_i(self_ref_req_i),
    .idle_o   (eng_idle),
    .ras_no   (ras_no),
    .cas_no   (cas_no)
  );

  assign we_no = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_no,
  input logic cas_no,
  input logic ready_o,
  input logic busy_o
);
  AST_CAS_LEADS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (!cas_no && !$past(cas_no))); // R3
  AST_CAS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cas_no) && !ras_no) |-> ($past(!ras_no) && $past(!ras_no, 2))); // R4
  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no || !cas_no) |-> busy_o); // R9
  AST_INIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> busy_o); // R9
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R2
  AST_RAS_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |=> ras_no); // R8
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ras_no (ras_no),
  .cas_no (cas_no),
  .ready_o(ready_o),
  .busy_o (busy_o)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int C_PAUSE = 25000;
  localparam int N_INIT  = 8;
  localparam int C_CSR   = 1;
  localparam int C_CHR   = 2;
  localparam int C_RPC   = 1;
  localparam int C_RASW  = 7;
  localparam int C_RP    = 4;
  localparam int C_INT   = 1950;
  localparam int C_RASS  = 12500;
  localparam int C_RPS   = 14;
  // hold cycles after column fall seen, expected row low length
  localparam int SR_VEC[3][2] = '{'{10, 12500}, '{12600, 12600}, '{13000, 13000}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 1'b0;
  logic ras_n, cas_n, we_n, ready, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_seq u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .self_ref_req_i(sr_req),
    .ras_no        (ras_n),
    .cas_no        (cas_n),
    .we_no         (we_n),
    .ready_o       (ready),
    .busy_o        (busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state, sampled on the falling edge
  int cyc = 0, first_act = 0, init_falls = 0, nfall = 0;
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000, chr = 0;
  int last_ras_lo = 0, last_gap = 0, fall_cyc[4];
  bit last_cas_cov = 1'b0;
  bit p_rs = 1'b1, p_cs = 1'b1, p_rdy = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (!we_n) chk(1'b0, "R6 we high", we_n, 1);
      if ((!ras_n || !cas_n) && !busy) chk(1'b0, "R9 busy while strobe low", busy, 1);
      if (!ready && !busy) chk(1'b0, "R9 busy before ready", busy, 1);
      if (first_act == 0 && (!ras_n || !cas_n)) first_act = cyc;
      if (p_cs && !cas_n) chk(cas_hi >= C_RPC, "R5 cas high before fall", cas_hi, C_RPC);
      if (p_rs && !ras_n) begin
        chk(!cas_n && cas_lo >= C_CSR, "R3 cas setup", cas_lo, C_CSR);
        chk(ras_hi >= C_RP, "R8 ras precharge", ras_hi, C_RP);
        last_gap = ras_hi;
        if (!ready) init_falls++;
        else begin
          if (nfall < 4) fall_cyc[nfall] = cyc;
          nfall++;
        end
      end
      if (!p_cs && cas_n && !ras_n) chk(chr >= C_CHR, "R4 cas hold", chr, C_CHR);
      if (!p_rs && ras_n) begin
        last_ras_lo  = ras_lo;
        last_cas_cov = (cas_lo >= ras_lo);
        if (p_cs) chk(ras_lo == C_RASW, "R12 refresh ras pulse", ras_lo, C_RASW);
      end
      if (!p_rdy && ready) begin
        chk(init_falls == N_INIT, "R2 init burst count", init_falls, N_INIT);
        chk(!busy, "R9 idle at ready", busy, 0);
      end
      if (p_rdy && !ready) chk(1'b0, "R2 ready dropped", ready, 1);
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      cas_lo = cas_n ? 0 : cas_lo + 1;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      if (ras_n) chr = 0;
      else if (!cas_n) chr++;
      p_rs = ras_n; p_cs = cas_n; p_rdy = ready;
    end
  end

  task automatic wait_ras_rise();
    do begin @(negedge clk); #1; end while (!(ras_n && last_ras_lo > 0 && ras_lo == 0 && ras_hi == 1));
  endtask

  task automatic wait_ras_fall();
    do begin @(negedge clk); #1; end while (!(!ras_n && ras_lo == 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 7);
    chk(!ready && busy, "R1 reset ready/busy", {ready, busy}, 1);
    rst_n = 1'b1;
    do begin @(negedge clk); #1; end while (!ready);
    chk(first_act > C_PAUSE, "R1 pause length", first_act, C_PAUSE + 2);
    do begin @(negedge clk); #1; end while (nfall < 4);
    for (int i = 1; i < 4; i++)
      chk(fall_cyc[i] - fall_cyc[i-1] == C_INT, "R7 refresh spacing", fall_cyc[i] - fall_cyc[i-1], C_INT);
    for (int v = 0; v < 3; v++) begin
      wait_ras_rise();
      sr_req = 1'b1;
      do begin @(negedge clk); #1; end while (cas_n);
      repeat (SR_VEC[v][0] - 1) @(negedge clk);
      @(negedge clk);
      sr_req = 1'b0;
      wait_ras_rise();
      chk(last_ras_lo == SR_VEC[v][1], "R10 self-refresh ras low", last_ras_lo, SR_VEC[v][1]);
      chk(last_cas_cov, "R10 cas low through self-refresh", last_cas_cov, 1);
      chk(ready, "R2 ready kept in self-refresh", ready, 1);
      wait_ras_fall();
      chk(last_gap == C_RPS + 3, "R11 pending refresh after exit", last_gap, C_RPS + 3);
    end
    // directed: reset in the middle of a refresh
    do begin @(negedge clk); #1; end while (cas_n);
    rst_n = 1'b0;
    #1;
    chk(ras_n && cas_n, "R1 mid-run reset strobes", {ras_n, cas_n}, 3);
    chk(!ready && busy, "R1 mid-run reset ready/busy", {ready, busy}, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog R1-timeout", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule